// File: doc/BRIEF.md
# Operating Mode Register with Write Lockout

This block holds the chip's three-bit operating mode inside an 8-bit register. While reset is active the mode follows three external strap pins. The strap value is kept when reset is released. After that, software can change the mode only through a narrow set of upgrades: single-chip to expanded, in either the normal or the emulation family. Any write outside that set leaves the mode as it is and arms a sticky lock, so a stray store cannot reconfigure the chip later. A secured device refuses upgrades and still arms the lock. Special modes, used for test and bring-up, accept any value and ignore both the lock and the secure state.

In the two emulation modes the register is shadowed by an external emulator. Reads return the external-bus data instead of the register, and every write strobe is also forwarded to the external bus. The current mode is also driven out directly so the rest of the chip can decode it.

Top module: `opmode_reg`

## Requirements
- R1: While `rst_n` is low, `mode` loads `mode_pins` on every clock edge. The value loaded at the last edge before release is held afterwards.
- R2: Encodings: 3'b000 special single-chip, 3'b001 emulation single-chip, 3'b010 special test, 3'b011 emulation expanded, 3'b100 normal single-chip, 3'b101 normal expanded. Outside emulation modes, `rd_data` is {mode, 5'b00000}: the mode sits in bits 7:5, and bits 4:0 read zero.
- R3: In normal single-chip (3'b100), with no lock and not secured, a write of 3'b101 in bits 7:5 moves the mode to 3'b101.
- R4: In emulation single-chip (3'b001), with no lock and not secured, a write of 3'b101 in bits 7:5 moves the mode to 3'b011.
- R5: In a non-special mode, a write that is not an authorized move leaves the mode unchanged and sets the lock. While the lock is set, every later write in that mode leaves the mode unchanged.
- R6: With `secure` high in a non-special mode, every write leaves the mode unchanged and sets the lock.
- R7: In special modes (3'b000, 3'b010), any write loads bits 7:5 into the mode, regardless of `secure` or the lock.
- R8: In emulation modes (3'b001, 3'b011), `rd_data` equals `ext_rd_data`, and `ext_wr_en` equals `wr_en`. In all other modes, `ext_wr_en` is 0.
- R9: Only data bits 7:5 are sampled. A write changes the mode at the clock edge that samples `wr_en` high, and not before.
- R10: The lock is cleared only by reset. After a fresh reset, an authorized move works again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| mode_pins | input | 3 | Strap pins for the mode |
| secure | input | 1 | Device secured flag |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data; bits 7:5 carry the requested mode |
| rd_data | output | DATA_W | Register read data |
| ext_rd_data | input | DATA_W | External-bus read data used in emulation modes |
| ext_wr_en | output | 1 | Write strobe forwarded to the external bus |
| mode | output | 3 | Current operating mode |

## Verification
The bench builds the block with its default DATA_W of 8, the width at which the mode field lands in bits 7:5. That placement makes both the zeroed low bits and the ignored low write bits visible at the ports. Every one of the six defined modes can be strapped directly, so the bench reaches each transition rule, the lock, the secure refusal and the emulation read path from a fresh reset.

// File: rtl/opm_pkg.sv
package opm_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_SPC_SC  = 3'b000,
    M_EMU_SC  = 3'b001,
    M_SPC_TST = 3'b010,
    M_EMU_EXP = 3'b011,
    M_NRM_SC  = 3'b100,
    M_NRM_EXP = 3'b101,
    M_RSV6    = 3'b110,
    M_RSV7    = 3'b111
  } opmode_e;

  localparam logic [MODE_W-1:0] UPGRADE_CODE = 3'b101;

  function automatic logic is_special(opmode_e m);
    return (m == M_SPC_SC) || (m == M_SPC_TST);
  endfunction

  function automatic logic is_emul(opmode_e m);
    return (m == M_EMU_SC) || (m == M_EMU_EXP);
  endfunction

  function automatic logic has_upgrade(opmode_e m);
    return (m == M_NRM_SC) || (m == M_EMU_SC);
  endfunction

  function automatic opmode_e upgrade_target(opmode_e m);
    return (m == M_EMU_SC) ? M_EMU_EXP : M_NRM_EXP;
  endfunction
endpackage

// File: rtl/opm_policy.sv
module opm_policy
  import opm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  opmode_e           cur_mode,
  input  logic              lock_q,
  input  logic              secure,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_field,
  output logic              take,
  output opmode_e           nxt_mode,
  output logic              set_lock
);
  logic ev_special_wr;
  logic ev_legal_wr;
  logic ev_reject_wr;

  always_comb begin
    ev_special_wr = wr_en && is_special(cur_mode);
    ev_legal_wr   = wr_en && !is_special(cur_mode) && !lock_q && !secure &&
                    has_upgrade(cur_mode) && (wr_field == UPGRADE_CODE);
    ev_reject_wr  = wr_en && !is_special(cur_mode) && !ev_legal_wr;
    take          = ev_special_wr || ev_legal_wr;
    nxt_mode      = ev_special_wr ? opmode_e'(wr_field) : upgrade_target(cur_mode);
    set_lock      = ev_reject_wr;
  end

  // R5: write outcomes are mutually exclusive
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_special_wr, ev_legal_wr, ev_reject_wr}));

  // R6: a secured non-special write is always rejected
  p_secure_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && secure && !is_special(cur_mode)) |-> (set_lock && !take));
endmodule

// File: rtl/opm_state.sv
module opm_state
  import opm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              take,
  input  opmode_e           nxt_mode,
  input  logic              set_lock,
  output opmode_e           mode_q,
  output logic              lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= opmode_e'(mode_pins);
      lock_q <= 1'b0;
    end else begin
      if (take)     mode_q <= nxt_mode;
      if (set_lock) lock_q <= 1'b1;
    end
  end

  // R1: first cycle out of reset holds the last strapped value
  p_strap_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode_q == opmode_e'($past(mode_pins))));

  // R10: the lock never clears outside reset
  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R5: a locked non-special mode does not move
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !is_special(mode_q)) |=> $stable(mode_q));

  // R6: a secure write outside special modes leaves the mode alone
  p_secure_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_lock && !take) |=> ($stable(mode_q) && lock_q));
endmodule

// File: rtl/opm_readmux.sv
module opm_readmux
  import opm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  opmode_e           mode_q,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] ext_rd_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              ext_wr_en
);
  localparam int PAD_W = DATA_W - MODE_W;

  logic              emul_active;
  logic [DATA_W-1:0] reg_view;

  always_comb begin
    emul_active = is_emul(mode_q);
    reg_view    = {mode_q, {PAD_W{1'b0}}};
    rd_data     = emul_active ? ext_rd_data : reg_view;
    ext_wr_en   = wr_en && emul_active;
  end

  // R2: unimplemented low bits read zero outside emulation
  p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !emul_active |-> (rd_data[PAD_W-1:0] == '0));

  // R8: forwarding only in emulation modes
  p_fwd_emul_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_en |-> (wr_en && (mode_q == M_EMU_SC || mode_q == M_EMU_EXP)));
endmodule

// File: rtl/opmode_reg.sv
module opmode_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_pins,
  input  logic              secure,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] ext_rd_data,
  output logic              ext_wr_en,
  output logic [2:0]        mode
);
  import opm_pkg::*;

  localparam int FIELD_MSB = DATA_W - 1;

  opmode_e           mode_q;
  opmode_e           nxt_mode;
  logic              lock_q;
  logic              take;
  logic              set_lock;
  logic [MODE_W-1:0] wr_field;

  assign wr_field = wr_data[FIELD_MSB -: MODE_W];
  assign mode     = mode_q;

  opm_policy u_policy (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_mode (mode_q),
    .lock_q   (lock_q),
    .secure   (secure),
    .wr_en    (wr_en),
    .wr_field (wr_field),
    .take     (take),
    .nxt_mode (nxt_mode),
    .set_lock (set_lock)
  );

  opm_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_pins (mode_pins),
    .take      (take),
    .nxt_mode  (nxt_mode),
    .set_lock  (set_lock),
    .mode_q    (mode_q),
    .lock_q    (lock_q)
  );

  opm_readmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_q),
    .wr_en       (wr_en),
    .ext_rd_data (ext_rd_data),
    .rd_data     (rd_data),
    .ext_wr_en   (ext_wr_en)
  );

  // R3: an accepted upgrade from normal single-chip lands in normal expanded
  p_nrm_upgrade_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_q == 3'b100 && !lock_q && !secure && wr_field == 3'b101)
      |=> (mode_q == 3'b101));

  // R4: an accepted upgrade from emulation single-chip lands in emulation expanded
  p_emu_upgrade_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_q == 3'b001 && !lock_q && !secure && wr_field == 3'b101)
      |=> (mode_q == 3'b011));

  // R7: special modes take any requested value
  p_special_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (mode_q == 3'b000 || mode_q == 3'b010)) |=> (mode_q == $past(wr_field)));

  // R9: no write strobe, no mode change
  p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rst_n) |=> $stable(mode_q));
endmodule

// File: tb/opmode_reg_tb_top.sv
`timescale 1ns/1ps
module opmode_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_pins = 3'b100;
  logic       secure = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] ext_rd_data = 8'h00;
  logic       ext_wr_en;
  logic [2:0] mode;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  opmode_reg #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .secure(secure),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ext_rd_data(ext_rd_data), .ext_wr_en(ext_wr_en), .mode(mode)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [2:0] p);
    @(negedge clk);
    rst_n = 1'b0; mode_pins = p; secure = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic do_write(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic t_strap;
    @(negedge clk);
    rst_n = 1'b0; mode_pins = 3'b000;
    @(negedge clk); #1;
    chk("R1 follow in reset", {5'b0, mode}, 8'h00);
    mode_pins = 3'b100;
    @(negedge clk);
    rst_n = 1'b1;
    mode_pins = 3'b010;
    #1;
    chk("R1 captured", {5'b0, mode}, 8'h04);
    @(negedge clk); #1;
    chk("R1 pins ignored after release", {5'b0, mode}, 8'h04);
    chk("R2 read view", rd_data, 8'h80);
  endtask

  task automatic t_normal_upgrade;
    do_reset(3'b100);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hBF;
    #1;
    chk("R9 not before edge", rd_data, 8'h80);
    chk("R8 no forward normal", {7'b0, ext_wr_en}, 8'h00);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R3 upgrade", rd_data, 8'hA0);
    chk("R9 low bits ignored", rd_data, 8'hA0);
  endtask

  task automatic t_bad_write_lock;
    do_reset(3'b100);
    do_write(8'h80);
    chk("R5 unchanged", rd_data, 8'h80);
    do_write(8'hA0);
    chk("R5 locked", rd_data, 8'h80);
    do_reset(3'b100);
    do_write(8'hA0);
    chk("R10 reset clears lock", rd_data, 8'hA0);
  endtask

  task automatic t_secure;
    do_reset(3'b100);
    secure = 1'b1;
    do_write(8'hA0);
    chk("R6 refused", rd_data, 8'h80);
    secure = 1'b0;
    do_write(8'hA0);
    chk("R6 lock set", rd_data, 8'h80);
  endtask

  task automatic t_emulation;
    do_reset(3'b001);
    ext_rd_data = 8'h5A;
    #1;
    chk("R8 ext read", rd_data, 8'h5A);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hA0;
    #1;
    chk("R8 forward", {7'b0, ext_wr_en}, 8'h01);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R4 emu upgrade", {5'b0, mode}, 8'h03);
    chk("R8 ext read expanded", rd_data, 8'h5A);
    do_reset(3'b001);
    do_write(8'h60);
    chk("R5 emu unchanged", {5'b0, mode}, 8'h01);
    do_write(8'hA0);
    chk("R5 emu locked", {5'b0, mode}, 8'h01);
  endtask

  task automatic t_special;
    do_reset(3'b000);
    secure = 1'b1;
    do_write(8'h40);
    chk("R7 special secure", {5'b0, mode}, 8'h02);
    chk("R2 special test read", rd_data, 8'h40);
    do_write(8'hFF);
    chk("R7 any value", {5'b0, mode}, 8'h07);
    do_reset(3'b010);
    do_write(8'h00);
    chk("R7 test to ssc", {5'b0, mode}, 8'h00);
    do_write(8'h9F);
    chk("R7 ssc to nsc", rd_data, 8'h80);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_strap();
    t_normal_upgrade();
    t_bad_write_lock();
    t_secure();
    t_emulation();
    t_special();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule